// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block keeps a small table of address-region descriptors and judges every bus access against it. An access presents a master number (0 to 7), a byte address, a kind (read, write or instruction fetch), a privilege level and a process ID. One clock later the block returns a permit or refuse verdict and a vector with one bit per descriptor that applied to the access.

Software programs the descriptors through a single-cycle register-write port. Each descriptor holds a start address, an end address, a rights word, a control word, and a second address for the same rights word, so that permissions can be changed without touching the bounds. A global enable input turns checking off, and every access is then permitted.

Masters split into two classes. Masters 0 to 3 have user and supervisor rights plus an optional process-ID filter. Masters 4 to 7 have only read and write bits. Descriptor 0 is partly protected against writes that come from the core master.

Top module: `mg_top`

## Requirements
- R1: After reset, chk_vld and chk_hit are zero and every descriptor is invalid. With prot_en set, any access is refused with an empty hit vector.
- R2: A start-address write stores the address with bits 4:0 cleared. An end-address write stores it with bits 4:0 set. An address is covered when start <= addr <= end.
- R3: A descriptor applies only when bit 0 of its control word (the valid bit) is 1.
- R4: In the rights word, master m (0..3) owns the 6 bits at 6m. Bits 2:0 give the user rights: read in bit 2, write in bit 1, fetch in bit 0. Bits 4:3 hold the supervisor code and bit 5 the process-ID enable. A user access (acc_priv=0) is granted by the matching user bit. acc_type encodes 0 as read, 1 as write and 2 as fetch.
- R5: A supervisor access (acc_priv=1) from masters 0..3 uses the supervisor code: 00 gives read/write/fetch, 01 gives read/fetch, 10 gives read/write, and 11 uses the user bits.
- R6: The control word holds the descriptor process ID in bits 15:8 and a don't-care mask in bits 23:16. When the requesting low master's enable bit is set, the descriptor applies only if the access PID equals the descriptor PID on every bit the mask leaves clear. Masters 4..7 are never filtered by PID.
- R7: Master m (4..7) owns 2 bits at 24+2(m-4): read in bit 1, write in bit 0. A fetch from these masters is never granted.
- R8: For a write with cfg_core=1 to descriptor 0, the start and end writes are ignored, and a rights write leaves the debugger master's field (master 1, bits 11:6) unchanged. Writes with cfg_core=0 are not restricted.
- R9: Selector 4 (the alternate rights address) writes the same rights word as selector 2 and leaves the addresses unchanged. The other selectors are 0 for start, 1 for end and 3 for control.
- R10: An access is permitted when at least one applying descriptor grants its kind to its master. Grants of overlapping descriptors are ORed, and chk_hit has bit i set for every descriptor i that applies.
- R11: With prot_en clear, every access is permitted, and the hit vector is still reported.
- R12: Each access presented with acc_vld is answered exactly one clock later with chk_vld. A descriptor write affects accesses presented from the next cycle on. With no access, chk_vld and chk_hit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_en | input | 1 | Global checking enable |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_core | input | 1 | Write comes from the core master |
| cfg_idx | input | $clog2(NREG) | Descriptor index |
| cfg_sel | input | 3 | Word select: 0 start, 1 end, 2 rights, 3 control, 4 alternate rights |
| cfg_wdata | input | 32 | Write data |
| acc_vld | input | 1 | Access present |
| acc_master | input | 3 | Requesting master number |
| acc_addr | input | AW | Access byte address |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | 1 supervisor, 0 user |
| acc_pid | input | 8 | Access process ID |
| chk_vld | output | 1 | Verdict present |
| chk_allow | output | 1 | Access permitted |
| chk_hit | output | NREG | Descriptors that applied |

## Verification
Accesses are placed one byte on each side of both rounded bounds, so an off-by-one compare or a missing rounding mask changes the verdict. Each supervisor code is tried against a user field that grants fetch only, which separates the four codes from each other and from the user path. Matching and mismatching PIDs are sent from a filtered low master and from an unfiltered high master to show that the filter removes the hit only where it should. Overlapping descriptors with disjoint grants, core writes against non-core writes to descriptor 0, and enable toggling show that the grants are ORed, that the lock applies only to the core and that the bypass still reports hits.

// File: rtl/mg_pkg.sv
package mg_pkg;
    localparam int OFS_W      = 5;   // region granule is 32 bytes
    localparam int PID_W      = 8;
    localparam int LOW_NUM    = 4;   // masters with full rights fields
    localparam int LOW_FW     = 6;
    localparam int HIGH_NUM   = 4;   // masters with read/write only
    localparam int HIGH_FW    = 2;
    localparam int HIGH_BASE  = LOW_NUM * LOW_FW;
    localparam int DBG_MASTER = 1;
    localparam logic [31:0] DBG_MASK = 32'(6'h3F) << (DBG_MASTER * LOW_FW);

    typedef enum logic [2:0] {
        SEL_START  = 3'd0,
        SEL_END    = 3'd1,
        SEL_RIGHTS = 3'd2,
        SEL_CTRL   = 3'd3,
        SEL_ALT    = 3'd4
    } sel_e;

    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_EX = 2'd2
    } acc_e;

    // rights as {read, write, fetch}
    function automatic logic [2:0] sup_rights(input logic [1:0] code, input logic [2:0] user);
        case (code)
            2'b00:   return 3'b111;
            2'b01:   return 3'b101;
            2'b10:   return 3'b110;
            default: return user;
        endcase
    endfunction
endpackage

// File: rtl/mg_desc_bank.sv
module mg_desc_bank
    import mg_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 32,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic                               cfg_core,
    input  logic [IDXW-1:0]                    cfg_idx,
    input  logic [2:0]                         cfg_sel,
    input  logic [31:0]                        cfg_wdata,
    output logic [NREG-1:0][AW-1:OFS_W]        st_o,
    output logic [NREG-1:0][AW-1:OFS_W]        en_o,
    output logic [NREG-1:0][31:0]              rt_o,
    output logic [NREG-1:0][31:0]              ct_o
);
    typedef struct packed {
        logic [NREG-1:0][AW-1:OFS_W] st;
        logic [NREG-1:0][AW-1:OFS_W] en;
        logic [NREG-1:0][31:0]       rt;
        logic [NREG-1:0][31:0]       ct;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  locked;

    always_comb begin
        bank_d = bank_q;
        locked = cfg_core && (cfg_idx == '0);
        if (cfg_we && (int'(cfg_idx) < NREG)) begin
            case (sel_e'(cfg_sel))
                SEL_START: if (!locked) bank_d.st[cfg_idx] = cfg_wdata[AW-1:OFS_W];
                SEL_END:   if (!locked) bank_d.en[cfg_idx] = cfg_wdata[AW-1:OFS_W];
                SEL_RIGHTS, SEL_ALT: begin
                    if (locked)
                        bank_d.rt[cfg_idx] = (cfg_wdata & ~DBG_MASK) | (bank_q.rt[cfg_idx] & DBG_MASK);
                    else
                        bank_d.rt[cfg_idx] = cfg_wdata;
                end
                SEL_CTRL:  bank_d.ct[cfg_idx] = cfg_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign st_o = bank_q.st;
    assign en_o = bank_q.en;
    assign rt_o = bank_q.rt;
    assign ct_o = bank_q.ct;
endmodule

// File: rtl/mg_region_eval.sv
module mg_region_eval
    import mg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:OFS_W] st_i,
    input  logic [AW-1:OFS_W] en_i,
    input  logic [31:0]       rt_i,
    input  logic [31:0]       ct_i,
    input  logic [2:0]        acc_master,
    input  logic [AW-1:0]     acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_priv,
    input  logic [PID_W-1:0]  acc_pid,
    output logic              hit_o,
    output logic              grant_o
);
    logic [LOW_FW-1:0]  low_f;
    logic [HIGH_FW-1:0] high_f;
    logic               is_low;
    logic               in_rng;
    logic               pid_ok;
    logic [2:0]         eff;
    logic               want;

    always_comb begin
        low_f  = '0;
        high_f = '0;
        for (int m = 0; m < LOW_NUM; m++)
            if (acc_master == 3'(m)) low_f = rt_i[m*LOW_FW +: LOW_FW];
        for (int m = 0; m < HIGH_NUM; m++)
            if (acc_master == 3'(m + LOW_NUM)) high_f = rt_i[HIGH_BASE + m*HIGH_FW +: HIGH_FW];

        is_low = int'(acc_master) < LOW_NUM;
        in_rng = (acc_addr >= {st_i, {OFS_W{1'b0}}}) && (acc_addr <= {en_i, {OFS_W{1'b1}}});
        pid_ok = !is_low || !low_f[5]
                 || (((acc_pid ^ ct_i[15:8]) & ~ct_i[23:16]) == '0);

        if (is_low) eff = acc_priv ? sup_rights(low_f[4:3], low_f[2:0]) : low_f[2:0];
        else        eff = {high_f[1], high_f[0], 1'b0};

        case (acc_e'(acc_type))
            ACC_RD:  want = eff[2];
            ACC_WR:  want = eff[1];
            ACC_EX:  want = eff[0];
            default: want = 1'b0;
        endcase

        hit_o   = ct_i[0] && in_rng && pid_ok;
        grant_o = hit_o && want;
    end
endmodule

// File: rtl/mg_top.sv
module mg_top
    import mg_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 32,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic              cfg_we,
    input  logic              cfg_core,
    input  logic [IDXW-1:0]   cfg_idx,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_vld,
    input  logic [2:0]        acc_master,
    input  logic [AW-1:0]     acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_priv,
    input  logic [7:0]        acc_pid,
    output logic              chk_vld,
    output logic              chk_allow,
    output logic [NREG-1:0]   chk_hit
);
    typedef struct packed {
        logic            vld;
        logic            allow;
        logic [NREG-1:0] hit;
    } res_t;

    logic [NREG-1:0][AW-1:OFS_W] st_all;
    logic [NREG-1:0][AW-1:OFS_W] en_all;
    logic [NREG-1:0][31:0]       rt_all;
    logic [NREG-1:0][31:0]       ct_all;
    logic [NREG-1:0]             hit_vec;
    logic [NREG-1:0]             grant_vec;
    res_t                        res_d, res_q;

    mg_desc_bank #(.NREG(NREG), .AW(AW)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_core  (cfg_core),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .st_o      (st_all),
        .en_o      (en_all),
        .rt_o      (rt_all),
        .ct_o      (ct_all)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        mg_region_eval #(.AW(AW)) eval_i (
            .st_i       (st_all[g]),
            .en_i       (en_all[g]),
            .rt_i       (rt_all[g]),
            .ct_i       (ct_all[g]),
            .acc_master (acc_master),
            .acc_addr   (acc_addr),
            .acc_type   (acc_type),
            .acc_priv   (acc_priv),
            .acc_pid    (acc_pid),
            .hit_o      (hit_vec[g]),
            .grant_o    (grant_vec[g])
        );
    end

    always_comb begin
        res_d.vld   = acc_vld;
        res_d.allow = acc_vld && (!prot_en || (|grant_vec));
        res_d.hit   = acc_vld ? hit_vec : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign chk_vld   = res_q.vld;
    assign chk_allow = res_q.allow;
    assign chk_hit   = res_q.hit;
endmodule

// File: rtl/mg_check.sv
module mg_check
    import mg_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 32,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        prot_en,
    input logic                        cfg_we,
    input logic                        cfg_core,
    input logic [IDXW-1:0]             cfg_idx,
    input logic [2:0]                  cfg_sel,
    input logic                        acc_vld,
    input logic [2:0]                  acc_master,
    input logic [1:0]                  acc_type,
    input logic                        chk_vld,
    input logic                        chk_allow,
    input logic [NREG-1:0]             chk_hit,
    input logic [NREG-1:0][AW-1:OFS_W] st_all,
    input logic [NREG-1:0][AW-1:OFS_W] en_all,
    input logic [NREG-1:0][31:0]       rt_all
);
    logic core_r0;
    assign core_r0 = cfg_we && cfg_core && (cfg_idx == '0);

    p_vld_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> chk_vld);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> (!chk_vld && chk_hit == '0 && !chk_allow));

    p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !prot_en) |=> chk_allow);

    p_allow_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && prot_en) |=> (!chk_allow || chk_hit != '0));

    p_no_high_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && prot_en && acc_master >= 3'd4 && acc_type == 2'd2) |=> !chk_allow);

    p_r0_start_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_r0 && cfg_sel == 3'd0) |=> $stable(st_all[0]));

    p_r0_end_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_r0 && cfg_sel == 3'd1) |=> $stable(en_all[0]));

    p_r0_dbg_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_r0 && (cfg_sel == 3'd2 || cfg_sel == 3'd4)) |=> $stable(rt_all[0][11:6]));
endmodule

bind mg_top mg_check #(.NREG(NREG), .AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .prot_en    (prot_en),
    .cfg_we     (cfg_we),
    .cfg_core   (cfg_core),
    .cfg_idx    (cfg_idx),
    .cfg_sel    (cfg_sel),
    .acc_vld    (acc_vld),
    .acc_master (acc_master),
    .acc_type   (acc_type),
    .chk_vld    (chk_vld),
    .chk_allow  (chk_allow),
    .chk_hit    (chk_hit),
    .st_all     (st_all),
    .en_all     (en_all),
    .rt_all     (rt_all)
);

// File: tb/mg_top_tb_top.sv
module mg_top_tb_top;
    localparam int  NREG = 4;
    localparam int  AW   = 32;
    localparam time TCK  = 20ns;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            prot_en = 1'b0;
    logic            cfg_we = 1'b0;
    logic            cfg_core = 1'b0;
    logic [1:0]      cfg_idx = '0;
    logic [2:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            acc_vld = 1'b0;
    logic [2:0]      acc_master = '0;
    logic [AW-1:0]   acc_addr = '0;
    logic [1:0]      acc_type = '0;
    logic            acc_priv = 1'b0;
    logic [7:0]      acc_pid = '0;
    logic            chk_vld;
    logic            chk_allow;
    logic [NREG-1:0] chk_hit;

    int total = 0;
    int bad   = 0;

    always #(TCK/2) clk = ~clk;

    mg_top #(.NREG(NREG), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
        .cfg_we(cfg_we), .cfg_core(cfg_core), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_vld(acc_vld), .acc_master(acc_master), .acc_addr(acc_addr),
        .acc_type(acc_type), .acc_priv(acc_priv), .acc_pid(acc_pid),
        .chk_vld(chk_vld), .chk_allow(chk_allow), .chk_hit(chk_hit)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [2:0] sel, input logic [31:0] data,
                      input logic core);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = data; cfg_core = core;
        @(negedge clk);
        cfg_we = 1'b0; cfg_core = 1'b0;
    endtask

    // presents one access; the verdict is registered at the next edge
    task automatic access(input logic [2:0] m, input logic [31:0] a, input logic [1:0] t,
                          input logic p, input logic [7:0] pid,
                          output logic al, output logic [NREG-1:0] h);
        @(negedge clk);
        acc_vld = 1'b1; acc_master = m; acc_addr = a; acc_type = t; acc_priv = p; acc_pid = pid;
        @(negedge clk);
        acc_vld = 1'b0;
        check("R12 verdict one cycle later", 32'(chk_vld), 32'd1);
        al = chk_allow;
        h  = chk_hit;
    endtask

    task automatic expect_acc(input string tag, input logic [2:0] m, input logic [31:0] a,
                              input logic [1:0] t, input logic p, input logic [7:0] pid,
                              input logic exp_al, input logic [NREG-1:0] exp_h);
        logic al;
        logic [NREG-1:0] h;
        access(m, a, t, p, pid, al, h);
        check({tag, " allow"}, 32'(al), 32'(exp_al));
        check({tag, " hit"}, 32'(h), 32'(exp_h));
    endtask

    task automatic t_reset();
        check("R1 chk_vld after reset", 32'(chk_vld), 32'd0);
        check("R1 chk_hit after reset", 32'(chk_hit), 32'd0);
        prot_en = 1'b1;
        expect_acc("R1 empty table", 3'd0, 32'h0000_1000, RD, 1'b1, 8'h00, 1'b0, 4'b0000);
        @(negedge clk);
        check("R12 idle chk_vld", 32'(chk_vld), 32'd0);
    endtask

    task automatic t_bounds();
        wr(2'd1, 3'd2, 32'h0000_0007, 1'b0);       // master0 user rwx
        wr(2'd1, 3'd0, 32'h0000_1007, 1'b0);
        wr(2'd1, 3'd1, 32'h0000_1020, 1'b0);
        wr(2'd1, 3'd3, 32'h0000_0001, 1'b0);
        expect_acc("R2 below start", 3'd0, 32'h0000_0FFF, RD, 1'b0, 8'h00, 1'b0, 4'b0000);
        expect_acc("R2 rounded start", 3'd0, 32'h0000_1000, RD, 1'b0, 8'h00, 1'b1, 4'b0010);
        expect_acc("R2 rounded end", 3'd0, 32'h0000_103F, RD, 1'b0, 8'h00, 1'b1, 4'b0010);
        expect_acc("R2 past end", 3'd0, 32'h0000_1040, RD, 1'b0, 8'h00, 1'b0, 4'b0000);
    endtask

    task automatic t_valid();
        wr(2'd1, 3'd3, 32'h0000_0000, 1'b0);
        expect_acc("R3 invalid descriptor", 3'd0, 32'h0000_1000, RD, 1'b0, 8'h00, 1'b0, 4'b0000);
        wr(2'd1, 3'd3, 32'h0000_0001, 1'b0);
        expect_acc("R3 valid again", 3'd0, 32'h0000_1000, RD, 1'b0, 8'h00, 1'b1, 4'b0010);
    endtask

    task automatic t_user();
        wr(2'd1, 3'd2, 32'h0000_4007, 1'b0);       // master2 user read only
        expect_acc("R4 user read", 3'd2, 32'h0000_1010, RD, 1'b0, 8'h00, 1'b1, 4'b0010);
        expect_acc("R4 user write", 3'd2, 32'h0000_1010, WR, 1'b0, 8'h00, 1'b0, 4'b0010);
        expect_acc("R4 user fetch", 3'd2, 32'h0000_1010, EX, 1'b0, 8'h00, 1'b0, 4'b0010);
    endtask

    task automatic t_sup();
        wr(2'd2, 3'd0, 32'h0000_2000, 1'b0);
        wr(2'd2, 3'd1, 32'h0000_2FFF, 1'b0);
        wr(2'd2, 3'd3, 32'h0000_0001, 1'b0);
        wr(2'd2, 3'd2, 32'h0000_0001, 1'b0);       // code 00, user fetch only
        expect_acc("R5 code00 write", 3'd0, 32'h0000_2100, WR, 1'b1, 8'h00, 1'b1, 4'b0100);
        wr(2'd2, 3'd2, 32'h0000_0009, 1'b0);       // code 01
        expect_acc("R5 code01 write", 3'd0, 32'h0000_2100, WR, 1'b1, 8'h00, 1'b0, 4'b0100);
        expect_acc("R5 code01 fetch", 3'd0, 32'h0000_2100, EX, 1'b1, 8'h00, 1'b1, 4'b0100);
        wr(2'd2, 3'd2, 32'h0000_0011, 1'b0);       // code 10
        expect_acc("R5 code10 fetch", 3'd0, 32'h0000_2100, EX, 1'b1, 8'h00, 1'b0, 4'b0100);
        expect_acc("R5 code10 write", 3'd0, 32'h0000_2100, WR, 1'b1, 8'h00, 1'b1, 4'b0100);
        wr(2'd2, 3'd2, 32'h0000_0019, 1'b0);       // code 11 -> user
        expect_acc("R5 code11 read", 3'd0, 32'h0000_2100, RD, 1'b1, 8'h00, 1'b0, 4'b0100);
        expect_acc("R5 code11 fetch", 3'd0, 32'h0000_2100, EX, 1'b1, 8'h00, 1'b1, 4'b0100);
    endtask

    task automatic t_pid();
        wr(2'd3, 3'd0, 32'h0000_3000, 1'b0);
        wr(2'd3, 3'd1, 32'h0000_30FF, 1'b0);
        wr(2'd3, 3'd2, 32'h009C_0000, 1'b0);       // master3: pid enable, user rwx
        wr(2'd3, 3'd3, 32'h000F_5A01, 1'b0);       // pid 5A, low nibble don't-care
        expect_acc("R6 pid match", 3'd3, 32'h0000_3010, RD, 1'b0, 8'h53, 1'b1, 4'b1000);
        expect_acc("R6 pid mismatch", 3'd3, 32'h0000_3010, RD, 1'b0, 8'h63, 1'b0, 4'b0000);
        expect_acc("R6 high master unfiltered", 3'd4, 32'h0000_3010, RD, 1'b0, 8'h63, 1'b0, 4'b1000);
    endtask

    task automatic t_high();
        wr(2'd3, 3'd2, 32'h389C_0000, 1'b0);       // master5 read, master6 read+write
        expect_acc("R7 m5 read", 3'd5, 32'h0000_3010, RD, 1'b1, 8'h00, 1'b1, 4'b1000);
        expect_acc("R7 m5 write", 3'd5, 32'h0000_3010, WR, 1'b1, 8'h00, 1'b0, 4'b1000);
        expect_acc("R7 m6 write", 3'd6, 32'h0000_3010, WR, 1'b0, 8'h00, 1'b1, 4'b1000);
        expect_acc("R7 m6 fetch", 3'd6, 32'h0000_3010, EX, 1'b1, 8'h00, 1'b0, 4'b1000);
    endtask

    task automatic t_alt();
        wr(2'd1, 3'd4, 32'h0000_0000, 1'b0);
        expect_acc("R9 alt clears rights", 3'd0, 32'h0000_1000, RD, 1'b0, 8'h00, 1'b0, 4'b0010);
        wr(2'd1, 3'd4, 32'h0000_0007, 1'b0);
        expect_acc("R9 alt restores rights", 3'd0, 32'h0000_103F, RD, 1'b0, 8'h00, 1'b1, 4'b0010);
    endtask

    task automatic t_overlap();
        wr(2'd0, 3'd0, 32'h0000_0000, 1'b0);
        wr(2'd0, 3'd1, 32'hFFFF_FFFF, 1'b0);
        wr(2'd0, 3'd2, 32'h0000_0004, 1'b0);       // master0 user read
        wr(2'd0, 3'd3, 32'h0000_0001, 1'b0);
        expect_acc("R10 neither grants", 3'd0, 32'h0000_2000, WR, 1'b0, 8'h00, 1'b0, 4'b0101);
        expect_acc("R10 region0 grants", 3'd0, 32'h0000_2000, RD, 1'b0, 8'h00, 1'b1, 4'b0101);
        expect_acc("R10 region2 grants", 3'd0, 32'h0000_2000, EX, 1'b0, 8'h00, 1'b1, 4'b0101);
    endtask

    task automatic t_lock();
        wr(2'd0, 3'd0, 32'h0000_5000, 1'b1);
        expect_acc("R8 core start ignored", 3'd0, 32'h0000_0000, RD, 1'b0, 8'h00, 1'b1, 4'b0001);
        wr(2'd0, 3'd1, 32'h0000_0010, 1'b1);
        expect_acc("R8 core end ignored", 3'd0, 32'h0000_0200, RD, 1'b0, 8'h00, 1'b1, 4'b0001);
        wr(2'd0, 3'd2, 32'hFFFF_FFFF, 1'b1);
        expect_acc("R8 debugger field kept", 3'd1, 32'h0000_0100, RD, 1'b0, 8'h00, 1'b0, 4'b0001);
        expect_acc("R8 other field written", 3'd0, 32'h0000_0100, WR, 1'b0, 8'h00, 1'b1, 4'b0001);
        wr(2'd0, 3'd0, 32'h0000_0100, 1'b0);
        expect_acc("R8 non-core start accepted", 3'd0, 32'h0000_0000, RD, 1'b0, 8'h00, 1'b0, 4'b0000);
    endtask

    task automatic t_disable();
        prot_en = 1'b0;
        expect_acc("R11 bypass fetch", 3'd7, 32'h0000_9000, EX, 1'b0, 8'h00, 1'b1, 4'b0001);
        prot_en = 1'b1;
        expect_acc("R11 enabled fetch", 3'd7, 32'h0000_9000, EX, 1'b0, 8'h00, 1'b0, 4'b0001);
    endtask

    initial begin
        #(TCK * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bounds();
        t_valid();
        t_user();
        t_sup();
        t_pid();
        t_high();
        t_alt();
        t_overlap();
        t_lock();
        t_disable();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule